// File: doc/BRIEF.md
# Multiplexed LCD drive sequencer

This block generates the time-multiplexed drive pattern for a passive-matrix liquid-crystal panel with 18 row electrodes and 80 column electrodes. It divides a fixed frame of 3072 clocks into row slots, chooses which row is selected in each slot, and gives every row and column output a 3-bit bias-level code. An analog level generator outside the block turns each code into a voltage. On every second frame the block flips polarity, so the cells see no net DC.

Three multiplex ratios are supported. The full ratio scans all 18 rows with a five-level bias scheme. The half ratio scans 9 rows: the first eight character rows plus the first icon row, also with five levels. The icon-only ratio scans just the two icon rows and uses a four-level scheme. The upstream logic watches the row index output and presents on `pix_row` the pixel bits for the row currently selected. A power-down input forces every output to ground level. Sequencing keeps running while power-down is active.

Top module: `lcd_mux_seq`

## Requirements
- R1: A frame is exactly 3072 clocks long. `frame_start_o` is high only in the first clock of each frame. `odd_frame_o` toggles at every frame boundary.
- R2: Level codes are: 0 = ground, 1 = one quarter, 2 = one half, 3 = three quarters, 4 = full LCD voltage, 5 = one third, 6 = two thirds. Row r (0-based, r = 0 is the first row) occupies `row_lvl_o[3r+2:3r]`. Column c occupies `col_lvl_o[3c+2:3c]`, and its pixel bit is `pix_row[c]`.
- R3: Mode code 0 (1:18) scans rows 0 to 17 in order in slots of 170 clocks. The last slot takes the 12 extra clocks and lasts 182 clocks.
- R4: Mode code 1 (1:9) scans rows 0 to 7 and then row 16 in slots of 341 clocks, with the last slot 344 clocks long. Rows 8 to 15 and row 17 are never selected and stay at the unselected level.
- R5: Mode code 2 (1:2, icon only) scans row 16 and then row 17, each for 1536 clocks. Rows 0 to 15 stay at the unselected level.
- R6: In modes 1:18 and 1:9 on an even frame, the selected row is at 4 and unselected rows are at 1. A column with its pixel on is at 0, and a column with its pixel off is at 2. On an odd frame the values are 0, 3, 4 and 2 in the same order.
- R7: In mode 1:2 on an even frame, the selected row is at 4, unselected rows are at 5, on columns are at 0 and off columns are at 6. On an odd frame the values are 0, 6, 4 and 5.
- R8: `mode_sel` is sampled only at the clock that ends a frame. A change made in the middle of a frame takes effect at the start of the next frame.
- R9: Mode code 3 behaves exactly like mode code 0.
- R10: While `pwr_down` is high, every row and column output is 0. The row sequencing continues, and `row_idx_o` keeps advancing.
- R11: During reset and in the first clock after it, the frame is even, the 1:18 mode is active, row 0 is selected and `frame_start_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one frame is 3072 of its cycles |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Multiplex ratio request: 0 = 1:18, 1 = 1:9, 2 = 1:2, 3 = same as 0 |
| pwr_down | input | 1 | Forces all outputs to the ground level |
| pix_row | input | 80 | Pixel bits of the currently selected row, one per column |
| row_idx_o | output | 5 | Index of the row selected in the current slot |
| frame_start_o | output | 1 | High in the first clock of each frame |
| odd_frame_o | output | 1 | Polarity of the current frame (1 = inverted) |
| row_lvl_o | output | 54 | Bias-level codes of the 18 rows, 3 bits each |
| col_lvl_o | output | 240 | Bias-level codes of the 80 columns, 3 bits each |

## Verification
The assertions check the following on every cycle:
- the frame position stays in range;
- polarity flips only at the end of a frame;
- the active mode stays fixed within a frame;
- the slot index stays below the slot count of the mode, and the last slot is reached by the end of the frame;
- the 1:9 mode never selects an unused row;
- exactly one row sits at an extreme level whenever power is on;
- power-down grounds all outputs.

Only the directed scenarios can show the rest:
- the exact slot boundaries in each ratio, including the longer final slot;
- the actual code values for both polarities;
- the one-frame delay before a new mode takes effect;
- the handling of the reserved mode code;
- that sequencing continues through power-down.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    typedef enum logic [1:0] {
        MX_FULL = 2'd0,
        MX_HALF = 2'd1,
        MX_ICON = 2'd2,
        MX_RSVD = 2'd3
    } mux_e;

    typedef enum logic [2:0] {
        LV_VSS  = 3'd0,
        LV_Q1   = 3'd1,
        LV_HALF = 3'd2,
        LV_Q3   = 3'd3,
        LV_VLCD = 3'd4,
        LV_T1   = 3'd5,
        LV_T2   = 3'd6
    } lvl_e;

    localparam int unsigned LVL_W = 3;

    typedef struct packed {
        mux_e mode;
        logic odd;
        logic pd;
    } drv_ctl_t;

    function automatic mux_e norm_mode(mux_e m);
        return (m == MX_RSVD) ? MX_FULL : m;
    endfunction

    function automatic int unsigned map_row(mux_e m, int unsigned slot,
                                            int unsigned rows);
        case (m)
            MX_HALF: return (slot < rows / 2 - 1) ? slot : rows - 2;
            MX_ICON: return rows - 2 + slot;
            default: return slot;
        endcase
    endfunction

    function automatic lvl_e row_level(drv_ctl_t c, logic sel);
        if (c.pd)
            return LV_VSS;
        if (sel)
            return c.odd ? LV_VSS : LV_VLCD;
        if (c.mode == MX_ICON)
            return c.odd ? LV_T2 : LV_T1;
        return c.odd ? LV_Q3 : LV_Q1;
    endfunction

    function automatic lvl_e col_level(drv_ctl_t c, logic on);
        if (c.pd)
            return LV_VSS;
        if (on)
            return c.odd ? LV_VLCD : LV_VSS;
        if (c.mode == MX_ICON)
            return c.odd ? LV_T1 : LV_T2;
        return LV_HALF;
    endfunction

endpackage

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
    import lcd_seq_pkg::*;
#(
    parameter int unsigned FRAME_CLKS = 3072,
    parameter int unsigned NUM_ROWS   = 18
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [1:0]                    mode_req,
    output logic [$clog2(FRAME_CLKS)-1:0] frame_pos,
    output logic [$clog2(NUM_ROWS)-1:0]   slot_idx,
    output logic                          odd,
    output mux_e                          cur_mode
);
    localparam int unsigned PW      = $clog2(FRAME_CLKS);
    localparam int unsigned SW      = $clog2(NUM_ROWS);
    localparam int unsigned NS_FULL = NUM_ROWS;
    localparam int unsigned NS_HALF = NUM_ROWS / 2;
    localparam int unsigned NS_ICON = 2;
    localparam int unsigned B_FULL  = FRAME_CLKS / NS_FULL;
    localparam int unsigned B_HALF  = FRAME_CLKS / NS_HALF;
    localparam int unsigned B_ICON  = FRAME_CLKS / NS_ICON;

    logic [PW-1:0] slot_cnt;
    logic [PW-1:0] base_len;
    logic [SW:0]   nslots;
    logic          last_slot;
    logic          wrap;

    always_comb begin
        case (cur_mode)
            MX_HALF: begin base_len = PW'(B_HALF); nslots = (SW+1)'(NS_HALF); end
            MX_ICON: begin base_len = PW'(B_ICON); nslots = (SW+1)'(NS_ICON); end
            default: begin base_len = PW'(B_FULL); nslots = (SW+1)'(NS_FULL); end
        endcase
    end

    assign last_slot = ({1'b0, slot_idx} == nslots - 1'b1);
    assign wrap      = (frame_pos == PW'(FRAME_CLKS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_pos <= '0;
            slot_cnt  <= '0;
            slot_idx  <= '0;
            odd       <= 1'b0;
            cur_mode  <= MX_FULL;
        end else if (wrap) begin
            frame_pos <= '0;
            slot_cnt  <= '0;
            slot_idx  <= '0;
            odd       <= ~odd;
            cur_mode  <= norm_mode(mux_e'(mode_req));
        end else begin
            frame_pos <= frame_pos + 1'b1;
            if (!last_slot && slot_cnt == base_len - 1'b1) begin
                slot_cnt <= '0;
                slot_idx <= slot_idx + 1'b1;
            end else begin
                slot_cnt <= slot_cnt + 1'b1;
            end
        end
    end

    // R1
    pos_range_chk: assert property (@(posedge clk) disable iff (rst)
        frame_pos < PW'(FRAME_CLKS));

    // R1
    polarity_flip_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (odd != $past(odd)));

    // R1
    polarity_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(odd));

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(cur_mode));

    // R3
    slot_range_chk: assert property (@(posedge clk) disable iff (rst)
        {1'b0, slot_idx} < nslots);

    // R3
    last_slot_reached_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |-> last_slot);

endmodule

// File: rtl/lcd_row_driver.sv
module lcd_row_driver
    import lcd_seq_pkg::*;
#(
    parameter int unsigned NUM_ROWS = 18
) (
    input  logic                          clk,
    input  logic                          rst,
    input  drv_ctl_t                      ctl,
    input  logic [$clog2(NUM_ROWS)-1:0]   slot_idx,
    output logic [$clog2(NUM_ROWS)-1:0]   sel_row,
    output logic [NUM_ROWS*LVL_W-1:0]     row_lvl
);
    localparam int unsigned RW = $clog2(NUM_ROWS);

    assign sel_row = RW'(map_row(ctl.mode, int'(slot_idx), NUM_ROWS));

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        assign row_lvl[r*LVL_W +: LVL_W] = row_level(ctl, sel_row == RW'(r));
    end

    // R4
    half_unused_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.mode == MX_HALF) |->
            (sel_row < RW'(NUM_ROWS / 2 - 1) || sel_row == RW'(NUM_ROWS - 2)));

    // R5
    icon_rows_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.mode == MX_ICON) |-> (sel_row >= RW'(NUM_ROWS - 2)));

endmodule

// File: rtl/lcd_col_driver.sv
module lcd_col_driver
    import lcd_seq_pkg::*;
#(
    parameter int unsigned NUM_COLS = 80
) (
    input  drv_ctl_t                  ctl,
    input  logic [NUM_COLS-1:0]       pix,
    output logic [NUM_COLS*LVL_W-1:0] col_lvl
);
    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        assign col_lvl[c*LVL_W +: LVL_W] = col_level(ctl, pix[c]);
    end
endmodule

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq
    import lcd_seq_pkg::*;
#(
    parameter int unsigned FRAME_CLKS = 3072,
    parameter int unsigned NUM_ROWS   = 18,
    parameter int unsigned NUM_COLS   = 80
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [1:0]                  mode_sel,
    input  logic                        pwr_down,
    input  logic [NUM_COLS-1:0]         pix_row,
    output logic [$clog2(NUM_ROWS)-1:0] row_idx_o,
    output logic                        frame_start_o,
    output logic                        odd_frame_o,
    output logic [NUM_ROWS*3-1:0]       row_lvl_o,
    output logic [NUM_COLS*3-1:0]       col_lvl_o
);
    localparam int unsigned PW = $clog2(FRAME_CLKS);
    localparam int unsigned RW = $clog2(NUM_ROWS);

    logic [PW-1:0] frame_pos;
    logic [RW-1:0] slot_idx;
    logic          odd;
    mux_e          cur_mode;
    drv_ctl_t      ctl;

    lcd_frame_timer #(.FRAME_CLKS(FRAME_CLKS), .NUM_ROWS(NUM_ROWS)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .mode_req (mode_sel),
        .frame_pos(frame_pos),
        .slot_idx (slot_idx),
        .odd      (odd),
        .cur_mode (cur_mode)
    );

    always_comb begin
        ctl.mode = cur_mode;
        ctl.odd  = odd;
        ctl.pd   = pwr_down;
    end

    lcd_row_driver #(.NUM_ROWS(NUM_ROWS)) u_rows (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .slot_idx(slot_idx),
        .sel_row (row_idx_o),
        .row_lvl (row_lvl_o)
    );

    lcd_col_driver #(.NUM_COLS(NUM_COLS)) u_cols (
        .ctl    (ctl),
        .pix    (pix_row),
        .col_lvl(col_lvl_o)
    );

    assign frame_start_o = (frame_pos == '0);
    assign odd_frame_o   = odd;

    logic [NUM_ROWS-1:0] row_extreme;
    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_ext
        assign row_extreme[r] = (row_lvl_o[r*3 +: 3] == LV_VLCD) ||
                                (row_lvl_o[r*3 +: 3] == LV_VSS);
    end

    // R6
    one_selected_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_down |-> ($countones(row_extreme) == 1));

    // R10
    pd_ground_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_down |-> (row_lvl_o == '0 && col_lvl_o == '0));

endmodule

// File: tb/test_lcd_mux_seq.sv
module test_lcd_mux_seq;
    localparam int CLK_PERIOD = 10;
    localparam int FRAME      = 3072;
    localparam int ROWS       = 18;
    localparam int COLS       = 80;
    localparam int WD_CYCLES  = 60000;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [1:0]          mode_sel = 2'd0;
    logic                pwr_down = 1'b0;
    logic [COLS-1:0]     pix_row;
    logic [4:0]          row_idx_o;
    logic                frame_start_o;
    logic                odd_frame_o;
    logic [ROWS*3-1:0]   row_lvl_o;
    logic [COLS*3-1:0]   col_lvl_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    lcd_mux_seq i_lcd_mux_seq (
        .clk          (clk),
        .rst          (rst),
        .mode_sel     (mode_sel),
        .pwr_down     (pwr_down),
        .pix_row      (pix_row),
        .row_idx_o    (row_idx_o),
        .frame_start_o(frame_start_o),
        .odd_frame_o  (odd_frame_o),
        .row_lvl_o    (row_lvl_o),
        .col_lvl_o    (col_lvl_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(int t);
        while (cyc != t) @(negedge clk);
    endtask

    // Expected levels: icon = 4-level scheme
    function automatic int e_row(bit icon, bit odd, bit sel);
        if (sel) return odd ? 0 : 4;
        if (icon) return odd ? 6 : 5;
        return odd ? 3 : 1;
    endfunction

    function automatic int e_col(bit icon, bit odd, bit on);
        if (on) return odd ? 4 : 0;
        if (icon) return odd ? 5 : 6;
        return 2;
    endfunction

    task automatic check_levels(string req, int sel, bit icon, bit odd);
        chk(req, "row_idx", int'(row_idx_o), sel);
        chk(req, "odd_frame", int'(odd_frame_o), int'(odd));
        for (int r = 0; r < ROWS; r++)
            chk(req, $sformatf("row%0d level", r), int'(row_lvl_o[3*r +: 3]),
                e_row(icon, odd, r == sel));
        for (int c = 0; c < COLS; c++)
            chk(req, $sformatf("col%0d level", c), int'(col_lvl_o[3*c +: 3]),
                e_col(icon, odd, pix_row[c]));
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: state while reset is held
        check_levels("R11", 0, 1'b0, 1'b0);
        chk("R11", "frame_start", int'(frame_start_o), 1);
        rst = 1'b0;
        // R11: first cycle after release
        chk("R11", "row_idx after release", int'(row_idx_o), 0);
        chk("R11", "frame_start after release", int'(frame_start_o), 1);
    endtask

    task automatic t_full();
        mode_sel = 2'd0;
        wait_cyc(1);
        chk("R1", "frame_start mid frame", int'(frame_start_o), 0);
        wait_cyc(169);  chk("R3", "slot0 end", int'(row_idx_o), 0);
        wait_cyc(170);  check_levels("R6", 1, 1'b0, 1'b0);
        wait_cyc(2889); chk("R3", "slot16 end", int'(row_idx_o), 16);
        wait_cyc(2890); chk("R3", "last slot start", int'(row_idx_o), 17);
        wait_cyc(3071); chk("R3", "last slot long", int'(row_idx_o), 17);
        chk("R1", "frame_start before wrap", int'(frame_start_o), 0);
        wait_cyc(3072);
        chk("R1", "frame_start at wrap", int'(frame_start_o), 1);
        check_levels("R6", 0, 1'b0, 1'b1);
    endtask

    task automatic t_half();
        wait_cyc(3100);
        mode_sel = 2'd1;
        wait_cyc(3242); chk("R8", "old mode kept", int'(row_idx_o), 1);
        wait_cyc(6144); chk("R1", "frame2 start", int'(frame_start_o), 1);
        check_levels("R4", 0, 1'b0, 1'b0);
        wait_cyc(6484); chk("R4", "slot0 end", int'(row_idx_o), 0);
        wait_cyc(6485); chk("R4", "slot1", int'(row_idx_o), 1);
        wait_cyc(8531); chk("R4", "slot7", int'(row_idx_o), 7);
        wait_cyc(8872); check_levels("R4", 16, 1'b0, 1'b0);
        wait_cyc(9215); chk("R4", "last slot long", int'(row_idx_o), 16);
        wait_cyc(9216); check_levels("R6", 0, 1'b0, 1'b1);
    endtask

    task automatic t_icon();
        wait_cyc(9300);
        mode_sel = 2'd2;
        wait_cyc(12287); chk("R8", "1:9 until boundary", int'(row_idx_o), 16);
        wait_cyc(12288); check_levels("R7", 16, 1'b1, 1'b0);
        wait_cyc(13823); chk("R5", "first icon slot end", int'(row_idx_o), 16);
        wait_cyc(13824); check_levels("R5", 17, 1'b1, 1'b0);
        wait_cyc(15360); check_levels("R7", 16, 1'b1, 1'b1);
    endtask

    task automatic t_rsvd();
        wait_cyc(15400);
        mode_sel = 2'd3;
        wait_cyc(18432); check_levels("R9", 0, 1'b0, 1'b0);
        wait_cyc(18601); chk("R9", "slot0 end", int'(row_idx_o), 0);
        wait_cyc(18602); chk("R9", "slot1", int'(row_idx_o), 1);
    endtask

    task automatic t_pd();
        wait_cyc(18700);
        pwr_down = 1'b1;
        #1;
        chk("R10", "rows grounded", int'(row_lvl_o != '0), 0);
        chk("R10", "cols grounded", int'(col_lvl_o != '0), 0);
        wait_cyc(18772);
        chk("R10", "sequencing continues", int'(row_idx_o), 2);
        chk("R10", "rows still grounded", int'(row_lvl_o != '0), 0);
        chk("R10", "cols still grounded", int'(col_lvl_o != '0), 0);
        pwr_down = 1'b0;
        wait_cyc(18800);
        check_levels("R10", 2, 1'b0, 1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        // R2: even columns on, odd columns off
        for (int c = 0; c < COLS; c++) pix_row[c] = (c % 2 == 0);
        t_reset();
        t_full();
        t_half();
        t_icon();
        t_rsvd();
        t_pd();
        finish_run();
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", WD_CYCLES, 0);
        finish_run();
    end

endmodule